// File: doc/BRIEF.md
# Cyclic Pattern Memory with Segmented Readout

This block is the digital test-pattern source in front of a segmented current-steering converter. While the mode input is low, software loads a sample memory one byte at a time over a slow three-wire serial link. The link has an active-low frame select, a serial clock and a data line, and each byte is shifted in most significant bit first. A write address advances by itself after every completed byte. The lower half of the address space belongs to channel 0 and the upper half to channel 1.

While the mode input is high, each channel replays its own 512 samples in an endless loop. The memory hands over eight samples per read. Each sample becomes a 19-bit control word with two fields. The upper four bits of the sample become 15 unary lines, where each bit drives a fixed-size group. The lower four bits pass through a delay that matches the encoder. The eight encoded lanes then go through an 8-to-4 multiplexer stage and a 4-to-2 stage. This leaves each channel with an even stream and an odd stream. Each stream holds a sample for two clocks, and the odd stream updates one clock after the even stream. That puts the two streams half a stream period apart.

Either channel can be muted. A muted channel drives a constant idle code on both of its streams.

Top module: `pattern_replay`

## Requirements
- R1: After reset, and from the clock edge after the mode input is sampled low, every stream of an enabled channel outputs 0.
- R2: With frame select low, a byte is taken from eight rising serial-clock edges, first bit most significant. Bits already shifted in are dropped when frame select goes high before the eighth edge.
- R3: The write address advances by one per completed byte and carries across frames. Address 0 to 511 fills channel 0 sample 0 to 511, and 512 to 1023 fills channel 1. Every change of the mode input returns the address to 0.
- R4: Serial activity while the mode input is high changes no stored sample.
- R5: A stream word is {unary[14:0], s[3:0]}. Word bits [18:11] all equal s[7], bits [10:7] equal s[6], bits [6:5] equal s[5], bit [4] equals s[4], and bits [3:0] equal s[3:0].
- R6: Take the clock edge that first samples the mode input high as edge 0. Sample 0 of each channel appears on its even stream after edge 4, and sample 1 appears on its odd stream after edge 5.
- R7: Sample j of a channel appears on the even stream (j even) or the odd stream (j odd) after edge 4+j and holds for exactly two clocks. The two streams never change on the same edge.
- R8: After sample 511 a channel continues with sample 0, with no gap and no repeat.
- R9: While a channel's mute bit is 1, both of its streams show the encoding of idle code 0x80 in the same cycle. The other channel is unaffected. On release the channel shows its ongoing replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-synchronous clock, one tick per half stream period |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = load memory, 1 = replay |
| frameN | input | 1 | Serial frame select, active low |
| serClk | input | 1 | Serial bit clock, sampled on clk |
| serData | input | 1 | Serial data, taken on a rising serClk |
| chanOff | input | 2 | Per-channel mute, bit c mutes channel c |
| ch0EvenOut | output | 19 | Channel 0 even-sample control word |
| ch0OddOut | output | 19 | Channel 0 odd-sample control word |
| ch1EvenOut | output | 19 | Channel 1 even-sample control word |
| ch1OddOut | output | 19 | Channel 1 odd-sample control word |

## Verification
The properties assume the following about the inputs:
- `serClk` stays low and high for at least one clock each.
- `serData` is steady at a rising edge.
- The mute bits change only between clocks, so the skew and hold checks treat a mute change as an exception.

The stimulus drives every input on the falling clock edge. It holds the serial clock low and high for two clocks per bit, closes every frame on a byte boundary (apart from one deliberate short frame), and switches mode only once serial traffic is quiet.

// File: rtl/pattern_replay_pkg.sv
package pattern_replay_pkg;
  localparam int SAMPLE_W = 8;
  localparam int MSB_W    = 4;
  localparam int LSB_W    = SAMPLE_W - MSB_W;
  localparam int UNARY_W  = (1 << MSB_W) - 1;
  localparam int CW       = UNARY_W + LSB_W;
  localparam int LANES    = 8;
  localparam int HALF     = LANES / 2;
  localparam int CH_DEPTH = 512;
  localparam int N_CH     = 2;
  localparam int WORDS    = CH_DEPTH / LANES;
  localparam int AW       = $clog2(CH_DEPTH * N_CH);
  localparam int CAW      = $clog2(CH_DEPTH);
  localparam int CHW      = AW - CAW;
  localparam int LW       = $clog2(LANES);
  localparam int WAW      = $clog2(WORDS);
  localparam int PHW      = LW;
  localparam int BW       = $clog2(SAMPLE_W);

  typedef logic [CW-1:0] ctrl_word_t;

  typedef struct packed {
    logic                clear;
    logic                wrEn;
    logic [AW-1:0]       wrAddr;
    logic [SAMPLE_W-1:0] wrData;
    logic                rdEn;
    logic [WAW-1:0]      rdWord;
    logic [PHW-1:0]      phase;
  } strobe_t;

  // bit b of the MSB field drives 2**b unary lines starting at line 2**b - 1
  function automatic logic [UNARY_W-1:0] unaryOf(input logic [MSB_W-1:0] m);
    logic [UNARY_W-1:0] u;
    u = '0;
    for (int b = 0; b < MSB_W; b++) begin
      for (int i = 0; i < UNARY_W; i++) begin
        if (i >= (1 << b) - 1 && i < (1 << (b + 1)) - 1) u[i] = m[b];
      end
    end
    return u;
  endfunction

  function automatic ctrl_word_t encodeSample(input logic [SAMPLE_W-1:0] s);
    return {unaryOf(s[SAMPLE_W-1:LSB_W]), s[LSB_W-1:0]};
  endfunction
endpackage

// File: rtl/pattern_replay_ctrl.sv
module pattern_replay_ctrl
  import pattern_replay_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mode,
  input  logic    frameN,
  input  logic    serClk,
  input  logic    serData,
  output strobe_t strb
);
  logic                modeQ;
  logic                sckQ;
  logic [BW-1:0]       bitCnt;
  logic [SAMPLE_W-2:0] shiftQ;
  logic [AW-1:0]       wAddr;
  logic [WAW-1:0]      rAddr;
  logic [PHW-1:0]      phase;
  logic                wrEnQ;
  logic [AW-1:0]       wrAddrQ;
  logic [SAMPLE_W-1:0] wrDataQ;
  logic                modeChg;
  logic                sckRise;

  assign modeChg = mode ^ modeQ;
  assign sckRise = serClk & ~sckQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= 1'b0;
      sckQ    <= 1'b0;
      bitCnt  <= '0;
      shiftQ  <= '0;
      wAddr   <= '0;
      rAddr   <= '0;
      phase   <= '0;
      wrEnQ   <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      modeQ <= mode;
      sckQ  <= serClk;
      wrEnQ <= 1'b0;
      if (modeChg) begin
        wAddr  <= '0;
        bitCnt <= '0;
        rAddr  <= '0;
        phase  <= '1;                 // first replay cycle issues word 0
      end else if (mode) begin
        phase <= phase + 1'b1;
        if (phase == '1) rAddr <= rAddr + 1'b1;
      end else if (frameN) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shiftQ <= {shiftQ[SAMPLE_W-3:0], serData};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == BW'(SAMPLE_W - 1)) begin
          wrEnQ   <= 1'b1;
          wrDataQ <= {shiftQ, serData};
          wrAddrQ <= wAddr;
          wAddr   <= wAddr + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.clear  = ~mode;
    strb.wrEn   = wrEnQ;
    strb.wrAddr = wrAddrQ;
    strb.wrData = wrDataQ;
    strb.rdEn   = mode & ~modeChg & (phase == '1);
    strb.rdWord = rAddr;
    strb.phase  = phase;
  end
endmodule

// File: rtl/pattern_replay_lane.sv
module pattern_replay_lane
  import pattern_replay_pkg::*;
#(
  parameter int                  CH_ID      = 0,
  parameter logic [SAMPLE_W-1:0] IDLE_CODE  = 8'h80,
  parameter int                  ENC_STAGES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strb,
  input  logic       off,
  output ctrl_word_t evenOut,
  output ctrl_word_t oddOut
);
  logic [SAMPLE_W-1:0]            mem [WORDS][LANES];
  logic [LANES-1:0][SAMPLE_W-1:0] wordQ;
  logic                           wrHit;
  logic [WAW-1:0]                 wWord;
  logic [LW-1:0]                  wLane;
  logic                           flush;

  assign wrHit = strb.wrEn && (strb.wrAddr[AW-1:CAW] == CHW'(CH_ID));
  assign wWord = strb.wrAddr[CAW-1:LW];
  assign wLane = strb.wrAddr[LW-1:0];
  assign flush = rst | strb.clear;

  always_ff @(posedge clk) begin
    if (wrHit) mem[wWord][wLane] <= strb.wrData;
  end

  always_ff @(posedge clk) begin
    if (flush) wordQ <= '0;
    else if (strb.rdEn) begin
      for (int k = 0; k < LANES; k++) wordQ[k] <= mem[strb.rdWord][k];
    end
  end

  // MSB encoder and matched LSB delay line, ENC_STAGES registers each
  logic [UNARY_W-1:0] unaryPipe [ENC_STAGES][LANES];
  logic [LSB_W-1:0]   lsbPipe   [ENC_STAGES][LANES];
  logic [PHW-1:0]     phPipe    [ENC_STAGES];

  for (genvar s = 0; s < ENC_STAGES; s++) begin : g_enc
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (flush) begin
          phPipe[0] <= '0;
          for (int k = 0; k < LANES; k++) begin
            unaryPipe[0][k] <= '0;
            lsbPipe[0][k]   <= '0;
          end
        end else begin
          phPipe[0] <= strb.phase;
          for (int k = 0; k < LANES; k++) begin
            unaryPipe[0][k] <= unaryOf(wordQ[k][SAMPLE_W-1:LSB_W]);
            lsbPipe[0][k]   <= wordQ[k][LSB_W-1:0];
          end
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (flush) begin
          phPipe[s] <= '0;
          for (int k = 0; k < LANES; k++) begin
            unaryPipe[s][k] <= '0;
            lsbPipe[s][k]   <= '0;
          end
        end else begin
          phPipe[s] <= phPipe[s-1];
          for (int k = 0; k < LANES; k++) begin
            unaryPipe[s][k] <= unaryPipe[s-1][k];
            lsbPipe[s][k]   <= lsbPipe[s-1][k];
          end
        end
      end
    end
  end

  ctrl_word_t encLane [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign encLane[k] = {unaryPipe[ENC_STAGES-1][k], lsbPipe[ENC_STAGES-1][k]};
  end

  // first mux stage: eight lanes to four, switching halfway through a word
  ctrl_word_t     halfLane [HALF];
  logic [PHW-1:0] phHalf;
  logic [PHW-1:0] phEnc;
  assign phEnc = phPipe[ENC_STAGES-1];

  always_ff @(posedge clk) begin
    if (flush) begin
      phHalf <= '0;
      for (int k = 0; k < HALF; k++) halfLane[k] <= '0;
    end else begin
      phHalf <= phEnc;
      for (int k = 0; k < HALF; k++)
        halfLane[k] <= phEnc[PHW-1] ? encLane[k + HALF] : encLane[k];
    end
  end

  // second mux stage: four lanes to two streams, updated on alternate ticks
  ctrl_word_t evenQ, oddQ;
  always_ff @(posedge clk) begin
    if (flush) begin
      evenQ <= '0;
      oddQ  <= '0;
    end else if (!phHalf[0]) begin
      evenQ <= halfLane[{phHalf[1], 1'b0}];
    end else begin
      oddQ  <= halfLane[{phHalf[1], 1'b1}];
    end
  end

  ctrl_word_t idleWord;
  assign idleWord = encodeSample(IDLE_CODE);
  assign evenOut  = off ? idleWord : evenQ;
  assign oddOut   = off ? idleWord : oddQ;
endmodule

// File: rtl/pattern_replay_dpath.sv
module pattern_replay_dpath
  import pattern_replay_pkg::*;
#(
  parameter logic [SAMPLE_W-1:0] IDLE_CODE  = 8'h80,
  parameter int                  ENC_STAGES = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strb,
  input  logic [N_CH-1:0] chanOff,
  output ctrl_word_t      evenOut [N_CH],
  output ctrl_word_t      oddOut  [N_CH]
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pattern_replay_lane #(
      .CH_ID(c), .IDLE_CODE(IDLE_CODE), .ENC_STAGES(ENC_STAGES)
    ) u_lane (
      .clk(clk), .rst(rst), .strb(strb), .off(chanOff[c]),
      .evenOut(evenOut[c]), .oddOut(oddOut[c])
    );
  end
endmodule

// File: rtl/pattern_replay.sv
module pattern_replay
  import pattern_replay_pkg::*;
#(
  parameter logic [SAMPLE_W-1:0] IDLE_CODE  = 8'h80,
  parameter int                  ENC_STAGES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          frameN,
  input  logic          serClk,
  input  logic          serData,
  input  logic [1:0]    chanOff,
  output logic [CW-1:0] ch0EvenOut,
  output logic [CW-1:0] ch0OddOut,
  output logic [CW-1:0] ch1EvenOut,
  output logic [CW-1:0] ch1OddOut
);
  strobe_t    strb;
  ctrl_word_t evenW [N_CH];
  ctrl_word_t oddW  [N_CH];

  pattern_replay_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .frameN(frameN),
    .serClk(serClk), .serData(serData), .strb(strb)
  );

  pattern_replay_dpath #(.IDLE_CODE(IDLE_CODE), .ENC_STAGES(ENC_STAGES)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .chanOff(chanOff),
    .evenOut(evenW), .oddOut(oddW)
  );

  assign ch0EvenOut = evenW[0];
  assign ch0OddOut  = oddW[0];
  assign ch1EvenOut = evenW[1];
  assign ch1OddOut  = oddW[1];
endmodule

// File: rtl/pattern_replay_chk.sv
module pattern_replay_chk (
  input logic        clk,
  input logic        rst,
  input logic        mode,
  input logic [1:0]  chanOff,
  input logic [18:0] ch0EvenOut,
  input logic [18:0] ch0OddOut,
  input logic [18:0] ch1EvenOut,
  input logic [18:0] ch1OddOut
);
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode) && !chanOff[0]) |-> (ch0EvenOut == '0 && ch0OddOut == '0)); // R1

  AST_UNARY_GROUPS: assert property (@(posedge clk) disable iff (rst)
    (ch0EvenOut[18:11] == {8{ch0EvenOut[18]}}) && (ch0EvenOut[10:7] == {4{ch0EvenOut[10]}})
    && (ch0EvenOut[6:5] == {2{ch0EvenOut[6]}})); // R5

  AST_SKEW_CH0: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) && $stable(chanOff)) |-> !(!$stable(ch0EvenOut) && !$stable(ch0OddOut))); // R7

  AST_SKEW_CH1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) && $stable(chanOff)) |-> !(!$stable(ch1EvenOut) && !$stable(ch1OddOut))); // R7

  AST_HOLD_TWO: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) && $stable(chanOff) && !$stable(ch0EvenOut))
    |=> (!$past(mode) || !$stable(chanOff) || $stable(ch0EvenOut))); // R7
endmodule

bind pattern_replay pattern_replay_chk u_chk (.*);

// File: tb/pattern_replay_bench.sv
`timescale 1ns/1ps
module pattern_replay_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic        frameN = 1'b1;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic [1:0]  chanOff = 2'b00;
  logic [18:0] ch0EvenOut, ch0OddOut, ch1EvenOut, ch1OddOut;

  pattern_replay u_pattern_replay (
    .clk(clk), .rst(rst), .mode(mode), .frameN(frameN), .serClk(serClk),
    .serData(serData), .chanOff(chanOff), .ch0EvenOut(ch0EvenOut),
    .ch0OddOut(ch0OddOut), .ch1EvenOut(ch1EvenOut), .ch1OddOut(ch1OddOut)
  );

  always #2.5 clk = ~clk;

  int        checks = 0;
  int        errors = 0;
  bit        done = 0;
  string     curReq = "R1";
  logic [7:0] memM [1024];
  int        wptr = 0;
  bit        inRead = 0;
  int        n = 0;

  function automatic logic [18:0] benchEnc(input logic [7:0] s);
    logic [18:0] w;
    int b;
    w = '0;
    w[3:0] = s[3:0];
    for (int l = 0; l < 15; l++) begin
      if (l < 1) b = 4; else if (l < 3) b = 5; else if (l < 7) b = 6; else b = 7;
      w[4 + l] = s[b];
    end
    return w;
  endfunction

  function automatic logic [18:0] expStream(input int c, input int p);
    int j;
    if (!inRead || n < 4 + p) return '0;
    j = n - 4;
    if ((j % 2) != p) j = j - 1;
    return benchEnc(memM[c * 512 + (j % 512)]);
  endfunction

  task automatic checkWord(input string req, input string what,
                           input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h n=%0d", req, what, act, exp, n);
    end
  endtask

  // reference model, compared every clock away from the edge
  always @(posedge clk) begin
    if (rst) begin inRead = 0; n = 0; end
    else if (mode) begin
      if (!inRead) begin inRead = 1; n = 0; end
      else n++;
    end else inRead = 0;
    #2;
    if (!done) begin
      checkWord(curReq, "ch0 even", ch0EvenOut, chanOff[0] ? benchEnc(8'h80) : expStream(0, 0));
      checkWord(curReq, "ch0 odd",  ch0OddOut,  chanOff[0] ? benchEnc(8'h80) : expStream(0, 1));
      checkWord(curReq, "ch1 even", ch1EvenOut, chanOff[1] ? benchEnc(8'h80) : expStream(1, 0));
      checkWord(curReq, "ch1 odd",  ch1OddOut,  chanOff[1] ? benchEnc(8'h80) : expStream(1, 1));
    end
  end

  task automatic ticks(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] v, input int cnt);
    for (int i = 7; i > 7 - cnt; i--) begin
      @(negedge clk); serData = v[i]; serClk = 1'b0;
      ticks(2);
      serClk = 1'b1;
      ticks(1);
    end
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input bit keep);
    sendBits(v, 8);
    if (keep) begin
      memM[wptr] = v;
      wptr = (wptr + 1) % 1024;
    end
  endtask

  task automatic frameOn;
    @(negedge clk); frameN = 1'b0;
  endtask

  task automatic frameOff;
    ticks(3); frameN = 1'b1; ticks(2);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk); mode = m; wptr = 0;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    curReq = "R1";
    ticks(4);
    rst = 1'b0;
    ticks(6);
    // load all 1024 samples over many frames (R2, R3)
    curReq = "R2";
    for (int f = 0; f < 16; f++) begin
      frameOn();
      for (int i = 0; i < 64; i++) sendByte(8'((f * 64 + i) * 37 + 5), 1);
      frameOff();
      if (f == 3) begin
        // short frame: three bits then frame ends, must be dropped (R2)
        frameOn(); sendBits(8'hE0, 3); frameOff();
      end
    end
    setMode(1'b1);
    curReq = "R6"; ticks(12);
    curReq = "R5"; ticks(100);
    curReq = "R3"; ticks(380);
    curReq = "R8"; ticks(60);
    curReq = "R7"; ticks(100);
    // serial traffic while replaying must not reach memory (R4)
    curReq = "R4";
    frameOn();
    for (int i = 0; i < 4; i++) sendByte(8'h5A ^ 8'(i), 0);
    frameOff();
    ticks(420);
    curReq = "R9";
    @(negedge clk); chanOff = 2'b10; ticks(30);
    chanOff = 2'b01; ticks(30);
    chanOff = 2'b00; ticks(20);
    curReq = "R1";
    setMode(1'b0); ticks(10);
    chanOff = 2'b11; ticks(5);
    chanOff = 2'b00; ticks(5);
    // address returns to 0 after a mode change (R3)
    curReq = "R3";
    frameOn();
    sendByte(8'hFF, 1); sendByte(8'h00, 1); sendByte(8'hA5, 1);
    frameOff();
    setMode(1'b1);
    ticks(600);
    curReq = "R8";
    ticks(40);
    finishRun();
  end
endmodule